// File: doc/BRIEF.md
# Set/Clear/Toggle Aliased Control Register Bank

This block is a bank of 32-bit control registers behind a simple request/response bus. Its address space has two windows. The lower window holds plain read/write registers, each on its own word. The upper window, starting at byte offset 0x4000 of a 0x5000-byte region, gives every controlled register a group of four consecutive words. The first word is the register itself. The other three are write aliases that set, clear or toggle selected bits in one bus write, so software needs no read-modify-write sequence.

Every register value drives a flat output bus for downstream logic. At reset each register loads a parameterised value. A per-register lock mask forces designated lock-indication bits high on top of that value. A request is accepted in the cycle it is presented, because the bus is always ready. The response (read data and an error flag) is registered and appears one cycle later.

Top module: `rb_alias_bank`

## Requirements
- R1: On reset, plain register i holds PLAIN_RST[i] and aliased register j holds ALIAS_RST[j] | ALIAS_LOCK[j]. The defaults are plain 0 = 0x040116FF, plain 2 = 0xFFFFFFFF, aliased 0 = 0x80013001, aliased 1 = 0x80012000 and aliased 2 = 0x1018101B.
- R2: A word write to byte address 4*i with i < N_PLAIN replaces plain register i completely. A word read there returns its value.
- R3: A word write to byte address 0x4000 + 16*j, the base of aliased register j, replaces that register completely.
- R4: A word write to base + 4 (SET) leaves the register equal to its old value OR the write data.
- R5: A word write to base + 8 (CLR) leaves the register equal to its old value AND NOT the write data. This includes lock bits.
- R6: A word write to base + 12 (TOG) leaves the register equal to its old value XOR the write data.
- R7: A read from base + 4, + 8 or + 12 returns the base register's current value and changes no register.
- R8: req_ready_o is always high. rsp_valid_o is high exactly in the cycle after a cycle with req_valid_i high, and rsp_rdata_o carries the value the register held in the request cycle.
- R9: An access with req_addr_i[1:0] != 0, or with req_size_i other than 2'b10 (word), responds with rsp_err_o = 1 and rsp_rdata_o = 0, and changes no register.
- R10: An aligned word access to an unmapped word responds with rsp_err_o = 0. A read there returns 0, and a write there is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | Access size, 2'b10 = 32-bit word |
| req_addr_i | input | ADDR_W (15) | Byte address within the region |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after the request |
| rsp_err_o | output | 1 | Misaligned or non-word access |
| rsp_rdata_o | output | 32 | Read data; zero for writes, errors and unmapped words |
| plain_q_o | output | N_PLAIN*32 | Plain register values, register i at bits [32i+31:32i] |
| alias_q_o | output | N_ALIAS*32 | Aliased register values, register j at bits [32j+31:32j] |

## Verification
A chain of base, SET, CLR and TOG writes is applied to the same aliased register. Each write uses data that mixes bits that are already one with bits that are zero, so an OR, an AND-NOT, an XOR and a plain replace each leave a different result. Every step is read back through a different alias address, which separates the aliasing of reads from the write operation. Clearing a lock bit through CLR shows that the lock is only a reset value. Misaligned and sub-word writes aimed at a live register show that errors leave state untouched. Writes to the first word past each window show that unmapped words cannot alias onto real registers.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int unsigned DATA_W = 32;
  localparam logic [1:0]  SIZE_WORD = 2'b10;

  // position within a four-word alias group
  typedef enum logic [1:0] {
    OP_BASE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_TOG  = 2'd3
  } alias_op_e;
endpackage

// File: rtl/rb_decode.sv
module rb_decode import rb_pkg::*; #(
  parameter int unsigned ADDR_W       = 15,
  parameter int unsigned N_PLAIN      = 4,
  parameter int unsigned N_ALIAS      = 4,
  parameter int unsigned ALIAS_BASE   = 'h4000,
  parameter int unsigned REGION_BYTES = 'h5000,
  localparam int unsigned PIDX_W = (N_PLAIN > 1) ? $clog2(N_PLAIN) : 1,
  localparam int unsigned AIDX_W = (N_ALIAS > 1) ? $clog2(N_ALIAS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic              err_o,
  output logic              plain_hit_o,
  output logic [PIDX_W-1:0] plain_idx_o,
  output logic              alias_hit_o,
  output logic [AIDX_W-1:0] alias_idx_o,
  output alias_op_e         op_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned BLK_W  = WORD_W - 2;

  logic [WORD_W-1:0] word, rel_word;
  logic [BLK_W-1:0]  blk;
  logic              in_plain, in_alias;

  assign err_o    = (addr_i[1:0] != 2'b00) || (size_i != SIZE_WORD);
  assign word     = addr_i[ADDR_W-1:2];
  assign in_plain = addr_i < ADDR_W'(ALIAS_BASE);
  assign in_alias = (addr_i >= ADDR_W'(ALIAS_BASE)) && (addr_i < ADDR_W'(REGION_BYTES));
  assign rel_word = word - WORD_W'(ALIAS_BASE >> 2);
  assign blk      = rel_word[WORD_W-1:2];

  assign plain_hit_o = !err_o && in_plain && (word < WORD_W'(N_PLAIN));
  assign plain_idx_o = word[PIDX_W-1:0];
  assign alias_hit_o = !err_o && in_alias && (blk < BLK_W'(N_ALIAS));
  assign alias_idx_o = blk[AIDX_W-1:0];
  assign op_o        = alias_op_e'(rel_word[1:0]);
endmodule

// File: rtl/rb_plain_reg.sv
module rb_plain_reg import rb_pkg::*; #(
  parameter logic [DATA_W-1:0] RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/rb_alias_reg.sv
module rb_alias_reg import rb_pkg::*; #(
  parameter logic [DATA_W-1:0] RST  = '0,
  parameter logic [DATA_W-1:0] LOCK = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  alias_op_e         op_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    unique case (op_i)
      OP_SET:  nxt = q_o | wdata_i;
      OP_CLR:  nxt = q_o & ~wdata_i;
      OP_TOG:  nxt = q_o ^ wdata_i;
      default: nxt = wdata_i;
    endcase
  end

  // lock bits are forced only at reset; software may change them later
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST | LOCK;
    else if (we_i) q_o <= nxt;
  end
endmodule

// File: rtl/rb_alias_bank.sv
module rb_alias_bank import rb_pkg::*; #(
  parameter int unsigned ADDR_W       = 15,
  parameter int unsigned N_PLAIN      = 4,
  parameter int unsigned N_ALIAS      = 4,
  parameter int unsigned ALIAS_BASE   = 'h4000,
  parameter int unsigned REGION_BYTES = 'h5000,
  parameter logic [N_PLAIN-1:0][31:0] PLAIN_RST =
    {32'h0001_8D40, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0401_16FF},
  parameter logic [N_ALIAS-1:0][31:0] ALIAS_RST =
    {32'h0400_0080, 32'h1018_101B, 32'h0001_2000, 32'h0001_3001},
  parameter logic [N_ALIAS-1:0][31:0] ALIAS_LOCK =
    {32'h0000_0000, 32'h0000_0000, 32'h8000_0000, 32'h8000_0000}
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic                      req_we_i,
  input  logic [1:0]                req_size_i,
  input  logic [ADDR_W-1:0]         req_addr_i,
  input  logic [31:0]               req_wdata_i,
  output logic                      rsp_valid_o,
  output logic                      rsp_err_o,
  output logic [31:0]               rsp_rdata_o,
  output logic [N_PLAIN*32-1:0]     plain_q_o,
  output logic [N_ALIAS*32-1:0]     alias_q_o
);
  localparam int unsigned PIDX_W = (N_PLAIN > 1) ? $clog2(N_PLAIN) : 1;
  localparam int unsigned AIDX_W = (N_ALIAS > 1) ? $clog2(N_ALIAS) : 1;

  logic              dec_err, dec_plain, dec_alias, wr;
  logic [PIDX_W-1:0] plain_idx;
  logic [AIDX_W-1:0] alias_idx;
  alias_op_e         op;
  logic [N_PLAIN-1:0][DATA_W-1:0] plain_q;
  logic [N_ALIAS-1:0][DATA_W-1:0] alias_q;
  logic [DATA_W-1:0] rd_val;

  assign req_ready_o = 1'b1;

  rb_decode #(
    .ADDR_W(ADDR_W), .N_PLAIN(N_PLAIN), .N_ALIAS(N_ALIAS),
    .ALIAS_BASE(ALIAS_BASE), .REGION_BYTES(REGION_BYTES)
  ) i_decode (
    .addr_i(req_addr_i), .size_i(req_size_i), .err_o(dec_err),
    .plain_hit_o(dec_plain), .plain_idx_o(plain_idx),
    .alias_hit_o(dec_alias), .alias_idx_o(alias_idx), .op_o(op)
  );

  assign wr = req_valid_i && req_we_i && !dec_err;

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
    rb_plain_reg #(.RST(PLAIN_RST[g])) i_reg (
      .clk_i, .rst_ni,
      .we_i(wr && dec_plain && (plain_idx == PIDX_W'(g))),
      .wdata_i(req_wdata_i), .q_o(plain_q[g])
    );
  end

  for (genvar g = 0; g < N_ALIAS; g++) begin : g_alias
    rb_alias_reg #(.RST(ALIAS_RST[g]), .LOCK(ALIAS_LOCK[g])) i_reg (
      .clk_i, .rst_ni,
      .we_i(wr && dec_alias && (alias_idx == AIDX_W'(g))),
      .op_i(op), .wdata_i(req_wdata_i), .q_o(alias_q[g])
    );
  end

  // every alias of a group reads back its base register
  always_comb begin
    rd_val = '0;
    if (dec_plain)      rd_val = plain_q[plain_idx];
    else if (dec_alias) rd_val = alias_q[alias_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i && dec_err;
      rsp_rdata_o <= (req_valid_i && !req_we_i && !dec_err) ? rd_val : '0;
    end
  end

  assign plain_q_o = plain_q;
  assign alias_q_o = alias_q;
endmodule

// File: rtl/rb_alias_bank_chk.sv
module rb_alias_bank_chk import rb_pkg::*; #(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned N_PLAIN    = 4,
  parameter int unsigned N_ALIAS    = 4,
  parameter int unsigned ALIAS_BASE = 'h4000
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_valid_i,
  input logic                  req_we_i,
  input logic [1:0]            req_size_i,
  input logic [ADDR_W-1:0]     req_addr_i,
  input logic [31:0]           req_wdata_i,
  input logic                  rsp_valid_o,
  input logic                  rsp_err_o,
  input logic [31:0]           rsp_rdata_o,
  input logic [N_PLAIN*32-1:0] plain_q_o,
  input logic [N_ALIAS*32-1:0] alias_q_o
);
  logic bad, wr0;
  assign bad = (req_addr_i[1:0] != 2'b00) || (req_size_i != SIZE_WORD);
  assign wr0 = req_valid_i && req_we_i && !bad;

  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R8
  AST_NO_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R8
  AST_ERR_KEEPS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && bad) |=> ($stable(plain_q_o) && $stable(alias_q_o))); // R9
  AST_ERR_ZERO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_rdata_o == 32'h0)); // R9
  AST_READ_KEEPS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_we_i) |=> ($stable(plain_q_o) && $stable(alias_q_o))); // R7
  AST_SET_ORS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr0 && req_addr_i == ADDR_W'(ALIAS_BASE + 4)) |=>
    (alias_q_o[31:0] == ($past(alias_q_o[31:0]) | $past(req_wdata_i)))); // R4
  AST_CLR_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr0 && req_addr_i == ADDR_W'(ALIAS_BASE + 8)) |=>
    (alias_q_o[31:0] == ($past(alias_q_o[31:0]) & ~$past(req_wdata_i)))); // R5
  AST_TOG_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr0 && req_addr_i == ADDR_W'(ALIAS_BASE + 12)) |=>
    (alias_q_o[31:0] == ($past(alias_q_o[31:0]) ^ $past(req_wdata_i)))); // R6
endmodule

bind rb_alias_bank rb_alias_bank_chk #(
  .ADDR_W(ADDR_W), .N_PLAIN(N_PLAIN), .N_ALIAS(N_ALIAS), .ALIAS_BASE(ALIAS_BASE)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_we_i(req_we_i),
  .req_size_i(req_size_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
  .rsp_valid_o(rsp_valid_o), .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o),
  .plain_q_o(plain_q_o), .alias_q_o(alias_q_o)
);

// File: tb/test_rb_alias_bank.sv
module test_rb_alias_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_we = 1'b0;
  logic [1:0]  req_size = 2'b10;
  logic [14:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [127:0] plain_q, alias_q;
  int n_chk = 0, n_fail = 0;
  logic [31:0] rd;
  logic        er;

  always #10 clk = ~clk;

  rb_alias_bank i_rb_alias_bank (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_size_i(req_size), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err),
    .rsp_rdata_o(rsp_rdata), .plain_q_o(plain_q), .alias_q_o(alias_q)
  );

  typedef struct packed {
    logic [14:0] waddr;
    logic [31:0] wdata;
    logic [14:0] raddr;
    logic [31:0] exp;
  } vec_t;

  // write one address, read another, expected value after the write
  localparam vec_t VECS [10] = '{
    '{15'h4000, 32'h0000_00F0, 15'h4000, 32'h0000_00F0},  // R3 base replace
    '{15'h4004, 32'h0F00_0003, 15'h4004, 32'h0F00_00F3},  // R4 R7
    '{15'h4008, 32'h0000_00A2, 15'h4008, 32'h0F00_0051},  // R5 R7
    '{15'h400C, 32'hFF00_00FF, 15'h400C, 32'hF000_00AE},  // R6 R7
    '{15'h0004, 32'hDEAD_BEEF, 15'h0004, 32'hDEAD_BEEF},  // R2
    '{15'h4024, 32'h0000_0004, 15'h4020, 32'h1018_101F},  // R4
    '{15'h403C, 32'h0400_0081, 15'h4030, 32'h0000_0001},  // R6
    '{15'h4018, 32'h8000_0000, 15'h4010, 32'h0001_2000},  // R5 lock clearable
    '{15'h4040, 32'h1234_5678, 15'h4040, 32'h0000_0000},  // R10 past alias window
    '{15'h0010, 32'hCAFE_F00D, 15'h0010, 32'h0000_0000}   // R10 past plain window
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [14:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rdat, output logic err);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = addr; req_size = sz; req_wdata = wd;
    @(negedge clk);
    check("R8 rsp_valid after request", {31'b0, rsp_valid}, 32'h1);
    rdat = rsp_rdata; err = rsp_err;
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    check("R1 plain0", plain_q[31:0], 32'h0401_16FF);
    check("R1 plain2", plain_q[95:64], 32'hFFFF_FFFF);
    check("R1 alias0 with lock", alias_q[31:0], 32'h8001_3001);
    check("R1 alias1 with lock", alias_q[63:32], 32'h8001_2000);
    check("R1 alias2", alias_q[95:64], 32'h1018_101B);
    check("R8 no response idle", {31'b0, rsp_valid}, 32'h0);
    check("R8 ready", {31'b0, req_ready}, 32'h1);
    access(1'b0, 15'h4008, 2'b10, 32'h0, rd, er);
    check("R1 R7 alias0 read via CLR alias", rd, 32'h8001_3001);
    check("R7 alias read leaves reg", alias_q[31:0], 32'h8001_3001);

    foreach (VECS[i]) begin
      access(1'b1, VECS[i].waddr, 2'b10, VECS[i].wdata, rd, er);
      check("R2-R6,R10 write no error", {31'b0, er}, 32'h0);
      access(1'b0, VECS[i].raddr, 2'b10, 32'h0, rd, er);
      check($sformatf("vector %0d readback (R2 R3 R4 R5 R6 R7 R10)", i), rd, VECS[i].exp);
    end
    check("R3 R6 alias0 port", alias_q[31:0], 32'hF000_00AE);
    check("R10 plain regs untouched", plain_q[127:96], 32'h0001_8D40);

    // R9 misaligned and sub-word accesses
    access(1'b1, 15'h4005, 2'b10, 32'hFFFF_FFFF, rd, er);
    check("R9 misaligned err", {31'b0, er}, 32'h1);
    check("R9 misaligned rdata", rd, 32'h0);
    access(1'b1, 15'h4000, 2'b00, 32'h0000_0000, rd, er);
    check("R9 byte size err", {31'b0, er}, 32'h1);
    access(1'b0, 15'h0006, 2'b10, 32'h0, rd, er);
    check("R9 misaligned read err", {31'b0, er}, 32'h1);
    check("R9 misaligned read rdata", rd, 32'h0);
    check("R9 alias0 unchanged", alias_q[31:0], 32'hF000_00AE);
    access(1'b0, 15'h4000, 2'b10, 32'h0, rd, er);
    check("R9 alias0 readback", rd, 32'hF000_00AE);
    check("R10 mapped read no err", {31'b0, er}, 32'h0);

    // R8 response drops after idle cycle
    @(negedge clk);
    check("R8 rsp_valid low after idle", {31'b0, rsp_valid}, 32'h0);

    // R1 reset again restores lock bit
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 alias1 lock after re-reset", alias_q[63:32], 32'h8001_2000);
    check("R1 plain1 after re-reset", plain_q[63:32], 32'h0000_0000);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule